// File: doc/BRIEF.md
# Programmable bidirectional I/O cell

This block sits between the core logic and one pad. The core offers a data bit to drive (`core_out`). The cell returns the value it captured from the pad (`core_in`). The pad is modelled as three separate lines: an input, an output and an output enable. Static configuration inputs set how the cell behaves:

- whether the pad only receives, only drives, or works in both directions under three-state control;
- how the received value is captured: passed straight through, registered, or latched;
- which of two dedicated I/O clocks the capture element uses;
- which of twelve enable sources gates the driver in bidirectional mode.

Two overrides take precedence over every setting and release the pad to high impedance. The first is a low-active test enable. The second is a programming-mode flag. A slew configuration bit is carried to the pad unchanged.

The cell is instantiated once per pad. Configuration normally stays static during operation. The twelve enable sources are two chip-wide enables and ten enables shared among logic groups.

Top module: `prog_io_cell`

The control is arranged as two enumerated mode variables. Each has its own decode process.

The pad mode (`cfg_pad_mode`) has four states:
- `PAD_IN`: never drive.
- `PAD_OUT`: always drive.
- `PAD_BIDIR`: drive when the selected enable is high.
- `PAD_RSVD`: behaves as `PAD_IN`.

The capture mode (`cfg_in_mode`) has four states:
- `CAP_DIRECT`: combinational pass-through.
- `CAP_REG`: rising-edge register.
- `CAP_LATCH`: transparent-high latch.
- `CAP_RSVD`: behaves as `CAP_DIRECT`.

The only stored state is the capture register and the capture latch.

## Requirements
- R1: Pad mode 2'b00 (and the unused code 2'b11) never drives the pad. Pad mode 2'b01 drives whenever no override is active and ignores the enable select. Pad mode 2'b10 drives exactly when the selected enable is high.
- R2: In pad mode 2'b10, enable select 0 picks `glb_oe[0]`, select 1 picks `glb_oe[1]`, and select k for k in 2..11 picks `pt_oe[k-2]`.
- R3: In pad mode 2'b10, enable select values 12 to 15 keep the driver off whatever the enable sources are.
- R4: While `test_oe_n` is low, `pad_oe` is low in every mode.
- R5: While `prog_mode` is high, `pad_oe` is low in every mode.
- R6: Capture mode 2'b00 (and the unused code 2'b11) passes `pad_in` to `core_in` combinationally. Capture mode 2'b01 loads `pad_in` on the rising edge of the selected I/O clock and holds it between edges.
- R7: `cfg_clk_sel` = 0 selects `io_clk0` and 1 selects `io_clk1` for the capture register and latch. Edges of the other clock have no effect.
- R8: Capture mode 2'b10 is a latch. It follows `pad_in` while the selected clock is high and holds its value while the clock is low.
- R9: An active-low asynchronous `rst_n` clears the capture register and latch. In capture modes 2'b01 and 2'b10, `core_in` reads 0 while reset is asserted.
- R10: In pad mode 2'b01 (output only), `core_in` is 0.
- R11: `pad_out` always equals `core_out`, and `pad_slew` always equals `cfg_slew`.
- R12: In pad mode 2'b10 with the driver enabled, `core_in` in direct capture mode returns the driven value. With the driver off, it returns the external pad value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| io_clk0 | input | 1 | First dedicated I/O clock |
| io_clk1 | input | 1 | Second dedicated I/O clock |
| rst_n | input | 1 | Asynchronous active-low reset of capture state |
| cfg_pad_mode | input | 2 | Pad direction mode |
| cfg_in_mode | input | 2 | Input capture mode |
| cfg_clk_sel | input | 1 | Capture clock select |
| cfg_oe_sel | input | 4 | Output-enable source select |
| cfg_slew | input | 1 | Slew configuration bit, passed through |
| glb_oe | input | 2 | Chip-wide output enables |
| pt_oe | input | 10 | Shared group output enables |
| test_oe_n | input | 1 | Test override, low forces high impedance |
| prog_mode | input | 1 | Programming override, high forces high impedance |
| core_out | input | 1 | Data to drive onto the pad |
| pad_in | input | 1 | Value seen at the pad |
| pad_out | output | 1 | Data to the pad driver |
| pad_oe | output | 1 | Pad driver enable |
| pad_slew | output | 1 | Slew bit to the pad |
| core_in | output | 1 | Captured pad value to the core |

## Verification
The hardest case to reach is telling the two capture clocks apart. The bench uses two clocks of different frequency whose rising edges never coincide. It changes `pad_in` just after an edge of the selected clock. It then confirms that an intervening edge of the other clock leaves `core_in` unchanged before the selected clock's next edge loads the value. Latch checks follow the same pattern: the input is changed during the high phase and again during the low phase of each clock. The enable logic is swept exhaustively over all pad modes, selects and override combinations. For each select, both a one-hot and an inverted one-hot pattern are placed on the sources, so a wrong index always shows.

// File: rtl/prog_io_cell_pkg.sv
`timescale 1ns/1ps
package prog_io_cell_pkg;
    typedef enum logic [1:0] {
        PAD_IN    = 2'b00,
        PAD_OUT   = 2'b01,
        PAD_BIDIR = 2'b10,
        PAD_RSVD  = 2'b11
    } pad_mode_e;

    typedef enum logic [1:0] {
        CAP_DIRECT = 2'b00,
        CAP_REG    = 2'b01,
        CAP_LATCH  = 2'b10,
        CAP_RSVD   = 2'b11
    } cap_mode_e;
endpackage

// File: rtl/prog_io_cell_oe_mux.sv
`timescale 1ns/1ps
module prog_io_cell_oe_mux #(
    parameter int N_GLB = 2,
    parameter int N_PT  = 10,
    parameter int SEL_W = 4
) (
    input  logic [SEL_W-1:0] sel,
    input  logic [N_GLB-1:0] glb,
    input  logic [N_PT-1:0]  pt,
    output logic             en
);
    localparam int N_SRC = N_GLB + N_PT;

    logic [N_SRC-1:0] src;
    assign src = {pt, glb};

    // Codes at or above N_SRC select nothing and leave the enable low.
    always_comb begin
        en = 1'b0;
        for (int i = 0; i < N_SRC; i++) begin
            if (sel == SEL_W'(i)) en = src[i];
        end
    end
endmodule

// File: rtl/prog_io_cell_capture.sv
`timescale 1ns/1ps
module prog_io_cell_capture
    import prog_io_cell_pkg::*;
(
    input  logic      io_clk0,
    input  logic      io_clk1,
    input  logic      clk_sel,
    input  logic      rst_n,
    input  cap_mode_e mode,
    input  logic      d,
    output logic      q
);
    logic cap_clk;
    logic reg_q;
    logic lat_q;

    assign cap_clk = clk_sel ? io_clk1 : io_clk0;

    always_ff @(posedge cap_clk or negedge rst_n) begin
        if (!rst_n) reg_q <= 1'b0;
        else        reg_q <= d;
    end

    always_latch begin
        if (!rst_n)       lat_q = 1'b0;
        else if (cap_clk) lat_q = d;
    end

    always_comb begin
        unique case (mode)
            CAP_REG:    q = reg_q;
            CAP_LATCH:  q = lat_q;
            CAP_DIRECT,
            CAP_RSVD:   q = d;
            default:    q = d;
        endcase
    end
endmodule

// File: rtl/prog_io_cell.sv
`timescale 1ns/1ps
module prog_io_cell
    import prog_io_cell_pkg::*;
#(
    parameter int N_GLB = 2,
    parameter int N_PT  = 10
) (
    input  logic        io_clk0,
    input  logic        io_clk1,
    input  logic        rst_n,
    input  logic [1:0]  cfg_pad_mode,
    input  logic [1:0]  cfg_in_mode,
    input  logic        cfg_clk_sel,
    input  logic [3:0]  cfg_oe_sel,
    input  logic        cfg_slew,
    input  logic [1:0]  glb_oe,
    input  logic [9:0]  pt_oe,
    input  logic        test_oe_n,
    input  logic        prog_mode,
    input  logic        core_out,
    input  logic        pad_in,
    output logic        pad_out,
    output logic        pad_oe,
    output logic        pad_slew,
    output logic        core_in
);
    localparam int N_SRC = N_GLB + N_PT;
    localparam int SEL_W = $clog2(N_SRC);

    pad_mode_e pad_mode;
    cap_mode_e cap_mode;
    logic      sel_en;
    logic      drive_req;
    logic      cap_q;

    assign pad_mode = pad_mode_e'(cfg_pad_mode);
    assign cap_mode = cap_mode_e'(cfg_in_mode);

    prog_io_cell_oe_mux #(
        .N_GLB (N_GLB),
        .N_PT  (N_PT),
        .SEL_W (SEL_W)
    ) u_oe_mux (
        .sel (cfg_oe_sel[SEL_W-1:0]),
        .glb (glb_oe[N_GLB-1:0]),
        .pt  (pt_oe[N_PT-1:0]),
        .en  (sel_en)
    );

    prog_io_cell_capture u_capture (
        .io_clk0 (io_clk0),
        .io_clk1 (io_clk1),
        .clk_sel (cfg_clk_sel),
        .rst_n   (rst_n),
        .mode    (cap_mode),
        .d       (pad_in),
        .q       (cap_q)
    );

    // Driver request decoded from pad mode.
    always_comb begin
        unique case (pad_mode)
            PAD_OUT:   drive_req = 1'b1;
            PAD_BIDIR: drive_req = sel_en;
            PAD_IN,
            PAD_RSVD:  drive_req = 1'b0;
            default:   drive_req = 1'b0;
        endcase
    end

    // Overrides act at the last stage before the pad.
    always_comb begin
        pad_oe   = drive_req & test_oe_n & ~prog_mode;
        pad_out  = core_out;
        pad_slew = cfg_slew;
        core_in  = (pad_mode == PAD_OUT) ? 1'b0 : cap_q;
    end
endmodule

// File: rtl/prog_io_cell_chk.sv
`timescale 1ns/1ps
module prog_io_cell_chk
    import prog_io_cell_pkg::*;
(
    input logic       io_clk0,
    input logic       rst_n,
    input logic [1:0] cfg_pad_mode,
    input logic [1:0] cfg_in_mode,
    input logic       cfg_clk_sel,
    input logic [3:0] cfg_oe_sel,
    input logic       test_oe_n,
    input logic       prog_mode,
    input logic       pad_in,
    input logic       pad_oe,
    input logic       core_in
);
    a_r1_input_no_drive: assert property (@(posedge io_clk0) disable iff (!rst_n)
        (cfg_pad_mode == PAD_IN) |-> !pad_oe);

    a_r3_high_sel_off: assert property (@(posedge io_clk0) disable iff (!rst_n)
        (cfg_pad_mode == PAD_BIDIR && cfg_oe_sel >= 4'd12) |-> !pad_oe);

    a_r4_test_hiz: assert property (@(posedge io_clk0) disable iff (!rst_n)
        !test_oe_n |-> !pad_oe);

    a_r5_prog_hiz: assert property (@(posedge io_clk0) disable iff (!rst_n)
        prog_mode |-> !pad_oe);

    a_r10_out_only_zero: assert property (@(posedge io_clk0) disable iff (!rst_n)
        (cfg_pad_mode == PAD_OUT) |-> (core_in == 1'b0));

    a_r6_reg_capture: assert property (@(posedge io_clk0) disable iff (!rst_n)
        (cfg_in_mode == CAP_REG && !cfg_clk_sel && cfg_pad_mode != PAD_OUT)
        |=> (cfg_in_mode != CAP_REG || cfg_clk_sel || cfg_pad_mode == PAD_OUT
             || core_in == $past(pad_in)));

    // R9: capture state reads zero during reset
    always @(negedge io_clk0) begin
        if (!rst_n && (cfg_in_mode == CAP_REG || cfg_in_mode == CAP_LATCH))
            a_r9_reset_clear: assert (core_in == 1'b0);
    end
endmodule

bind prog_io_cell prog_io_cell_chk u_chk (
    .io_clk0      (io_clk0),
    .rst_n        (rst_n),
    .cfg_pad_mode (cfg_pad_mode),
    .cfg_in_mode  (cfg_in_mode),
    .cfg_clk_sel  (cfg_clk_sel),
    .cfg_oe_sel   (cfg_oe_sel),
    .test_oe_n    (test_oe_n),
    .prog_mode    (prog_mode),
    .pad_in       (pad_in),
    .pad_oe       (pad_oe),
    .core_in      (core_in)
);

// File: tb/prog_io_cell_tb.sv
`timescale 1ns/1ps
module prog_io_cell_tb;
    logic       io_clk0 = 1'b0;
    logic       io_clk1 = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] cfg_pad_mode = 2'b00;
    logic [1:0] cfg_in_mode = 2'b01;
    logic       cfg_clk_sel = 1'b0;
    logic [3:0] cfg_oe_sel = 4'd0;
    logic       cfg_slew = 1'b0;
    logic [1:0] glb_oe = 2'b00;
    logic [9:0] pt_oe = 10'd0;
    logic       test_oe_n = 1'b1;
    logic       prog_mode = 1'b0;
    logic       core_out = 1'b0;
    logic       ext_drive = 1'b0;
    logic       pad_in, pad_out, pad_oe, pad_slew, core_in;
    int         checks = 0;
    int         errors = 0;
    bit         done = 0;

    always #2.5 io_clk0 = ~io_clk0;   // 200 MHz
    always #5.0 io_clk1 = ~io_clk1;   // 100 MHz, rising edges never meet io_clk0's

    // Pad model: the driver wins when enabled.
    assign pad_in = pad_oe ? pad_out : ext_drive;

    prog_io_cell u_dut (
        .io_clk0(io_clk0), .io_clk1(io_clk1), .rst_n(rst_n),
        .cfg_pad_mode(cfg_pad_mode), .cfg_in_mode(cfg_in_mode),
        .cfg_clk_sel(cfg_clk_sel), .cfg_oe_sel(cfg_oe_sel), .cfg_slew(cfg_slew),
        .glb_oe(glb_oe), .pt_oe(pt_oe), .test_oe_n(test_oe_n),
        .prog_mode(prog_mode), .core_out(core_out), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_slew(pad_slew), .core_in(core_in)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wait_rise(input logic sel);
        if (sel) @(posedge io_clk1); else @(posedge io_clk0);
    endtask

    task automatic wait_fall(input logic sel);
        if (sel) @(negedge io_clk1); else @(negedge io_clk0);
    endtask

    initial begin
        #400000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic exp_q;
        // R9: reset state in registered and latched modes
        ext_drive = 1'b1;
        #3;
        chk("R9 reset reg", core_in, 1'b0);
        cfg_in_mode = 2'b10;
        #4;
        chk("R9 reset latch", core_in, 1'b0);
        @(negedge io_clk0);
        rst_n = 1'b1;
        cfg_in_mode = 2'b00;

        // R1..R5: exhaustive enable sweep
        for (int pm = 0; pm < 4; pm++)
            for (int s = 0; s < 16; s++)
                for (int t = 0; t < 2; t++)
                    for (int p = 0; p < 2; p++)
                        for (int pol = 0; pol < 2; pol++) begin
                            logic [11:0] oh;
                            logic sv, drv, exp_oe;
                            string tag;
                            oh = (s < 12) ? (12'd1 << s) : 12'd0;
                            if (pol == 1) oh = ~oh;
                            {pt_oe, glb_oe} = oh;
                            cfg_pad_mode = 2'(pm);
                            cfg_oe_sel = 4'(s);
                            test_oe_n = 1'(t);
                            prog_mode = 1'(p);
                            sv = (s < 12) ? (pol == 0) : 1'b0;
                            drv = (pm == 1) ? 1'b1 : (pm == 2) ? sv : 1'b0;
                            exp_oe = drv & (t == 1) & (p == 0);
                            if (t == 0) tag = "R4";
                            else if (p == 1) tag = "R5";
                            else if (pm == 2 && s >= 12) tag = "R3";
                            else if (pm == 2) tag = "R2";
                            else tag = "R1";
                            #1;
                            chk(tag, pad_oe, exp_oe);
                        end
        test_oe_n = 1'b1; prog_mode = 1'b0;

        // R11: pass-through of data and slew bit
        for (int v = 0; v < 4; v++) begin
            core_out = v[0]; cfg_slew = v[1];
            #1;
            chk("R11 data", pad_out, v[0]);
            chk("R11 slew", pad_slew, v[1]);
        end

        // R6: direct capture, including the unused code
        cfg_pad_mode = 2'b00;
        for (int m = 0; m < 2; m++)
            for (int v = 0; v < 2; v++) begin
                cfg_in_mode = (m == 0) ? 2'b00 : 2'b11;
                ext_drive = v[0];
                #1;
                chk("R6 direct", core_in, v[0]);
            end

        // R6/R7: registered capture on each clock
        cfg_in_mode = 2'b01;
        for (int cs = 0; cs < 2; cs++) begin
            cfg_clk_sel = cs[0];
            wait_rise(cs[0]); #1;
            exp_q = ext_drive;
            for (int i = 0; i < 6; i++) begin
                logic nv;
                nv = ((i * 5 + cs) % 3) != 0;
                ext_drive = nv;
                if (cs == 1) begin
                    @(posedge io_clk0); #1;
                    chk("R7 other clock ignored", core_in, exp_q);
                end else begin
                    #2;
                    chk("R6 hold between edges", core_in, exp_q);
                end
                wait_rise(cs[0]); #1;
                exp_q = nv;
                chk("R6 registered load", core_in, exp_q);
            end
        end

        // R8: latch on each clock
        cfg_in_mode = 2'b10;
        for (int cs = 0; cs < 2; cs++) begin
            cfg_clk_sel = cs[0];
            for (int i = 0; i < 3; i++) begin
                logic v;
                v = (i % 2) == 0;
                wait_rise(cs[0]); #0.5;
                ext_drive = v; #0.5;
                chk("R8 transparent", core_in, v);
                wait_fall(cs[0]); #0.5;
                ext_drive = ~v; #0.5;
                chk("R8 hold", core_in, v);
            end
        end

        // R10: output-only mode hides the pad
        cfg_pad_mode = 2'b01; ext_drive = 1'b1; core_out = 1'b1;
        for (int m = 0; m < 3; m++) begin
            cfg_in_mode = 2'(m);
            wait_rise(1'b1); #1;
            chk("R10 output only", core_in, 1'b0);
        end

        // R12: bidirectional readback
        cfg_pad_mode = 2'b10; cfg_in_mode = 2'b00; cfg_oe_sel = 4'd0;
        glb_oe = 2'b01;
        for (int v = 0; v < 2; v++) begin
            core_out = v[0]; ext_drive = ~v[0];
            #1;
            chk("R12 driven readback", core_in, v[0]);
        end
        glb_oe = 2'b00;
        for (int v = 0; v < 2; v++) begin
            core_out = ~v[0]; ext_drive = v[0];
            #1;
            chk("R12 external readback", core_in, v[0]);
        end

        // R9: asynchronous reset mid-run
        cfg_pad_mode = 2'b00; cfg_in_mode = 2'b01; cfg_clk_sel = 1'b0;
        ext_drive = 1'b1;
        wait_rise(1'b0); #1;
        chk("R9 loaded before reset", core_in, 1'b1);
        rst_n = 1'b0; #1;
        chk("R9 async clear", core_in, 1'b0);
        @(negedge io_clk0); rst_n = 1'b1;
        #1;

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule